// File: doc/BRIEF.md
# Three-Phase Reactive Energy Pulse Accumulator

This block turns signed reactive power samples from three phases into signed energy counts. Each phase keeps a wide signed residue accumulator. The accumulator adds one power sample whenever the sample strobe is high, which happens at the fixed metering sample rate (one strobe every 125 µs at 8 kHz). When the residue rises to the programmable threshold, the block removes one threshold's worth of energy and sends a positive unit pulse. When the residue falls to the negative threshold, the block adds one threshold back and sends a negative unit pulse. Each pulse moves the signed energy register of its phase by one count.

Phases A and C always integrate their own power product. The power fed to phase B comes from a two-bit source selector. It can be phase B's own product, zero, or a product that the block computes from the phase B current term and a voltage synthesised from the other phases. That voltage is either the negated sum of the A and C voltages or the negated A voltage. These synthesised options serve wiring arrangements in which phase B's voltage is not measured. Setting the threshold to the largest per-sample value gives at most one pulse per sample. With 32-bit registers, that full-scale rate holds for roughly 74.5 hours before a register wraps.

A synchronous clear empties every accumulator and register. Energy registers wrap in two's complement and keep a sticky overflow flag for each phase.

Top module: `rea_top`

## Requirements
- R1: While the strobe is low and clear is low, neither pulse output of any phase is high on the following cycle, and no energy register, overflow flag or residue changes.
- R2: Phases A and C integrate `pa_prod` and `pc_prod` under every value of `bsel`.
- R3: The `bsel` field picks the phase B sample as follows: 2'b00 selects `pb_prod`, 2'b01 selects zero, 2'b10 selects (−va − vc)·ib, and 2'b11 selects (−va)·ib. The arithmetic is signed and exact, with no truncation.
- R4: On a strobe, a phase's new residue is its old residue plus its sample. If that new residue is greater than or equal to `thr`, the block subtracts `thr`, and `pulse_pos` for that phase is high for the single cycle after the strobe.
- R5: On a strobe, if the new residue is less than or equal to −`thr` and no positive pulse applies, the block adds `thr`, and `pulse_neg` is high for the single cycle after the strobe.
- R6: If the sample held on a phase equals `thr` on every strobe, that phase sends one positive pulse per strobe.
- R7: Each energy register is a signed EN_W-bit value. A positive pulse adds one to it and a negative pulse subtracts one, and the register shows its new value in the same cycle that the pulse is visible.
- R8: A register steps from the most positive value to the most negative value on an increment, and from the most negative value to the most positive value on a decrement. Either wrap sets that phase's `ovf` bit, and the bit stays set until clear or reset.
- R9: A clear sampled high zeroes every residue, energy register, pulse output and overflow flag on the next cycle, and clear takes priority over a strobe in the same cycle.
- R10: While `rst_n` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear of all accumulation state |
| smp_en | input | 1 | Sample strobe: one accumulation step |
| thr | input | TH_W | Unsigned pulse threshold |
| bsel | input | 2 | Phase B source selector |
| pa_prod | input | PROD_W | Signed phase A power product |
| pb_prod | input | PROD_W | Signed phase B power product |
| pc_prod | input | PROD_W | Signed phase C power product |
| va | input | V_W | Signed phase A voltage term |
| vc | input | V_W | Signed phase C voltage term |
| ib | input | I_W | Signed, phase-shifted phase B current term |
| energy | output | 3×EN_W | Signed energy registers; index 0 = A, 1 = B, 2 = C |
| pulse_pos | output | 3 | Positive energy pulse per phase |
| pulse_neg | output | 3 | Negative energy pulse per phase |
| ovf | output | 3 | Sticky wrap flag per phase |

## Verification
The bench builds the block with 8-bit energy registers and 8-bit voltage and current terms. With these values, a few hundred strobes at a small threshold push a register through both wrap directions, and the synthesised phase B products stay small enough to stress every selector value. It also uses thresholds equal to the held sample, so the one-pulse-per-strobe case and both crossing directions appear within tens of cycles. The bench's behavioural model tracks each residue exactly, so the comparison covers every pulse instant and not only the final counts.

// File: rtl/rea_pkg.sv
// Shared types for the reactive energy pulse accumulator.
package rea_pkg;

    // Source selected for the phase B power sample
    typedef enum logic [1:0] {
        BSRC_OWN    = 2'b00,
        BSRC_ZERO   = 2'b01,
        BSRC_NEG_AC = 2'b10,
        BSRC_NEG_A  = 2'b11
    } bsrc_e;

endpackage

// File: rtl/rea_bsel.sv
// rea_bsel: forms the phase B power sample.
// Selects phase B's own product, zero, or a product of the phase B current
// with a synthesised voltage (-va - vc or -va).
// Assumes PROD_W >= V_W + I_W + 2, so the synthesised products fit exactly.
module rea_bsel #(
    parameter int V_W    = 16,
    parameter int I_W    = 16,
    parameter int PROD_W = 36
) (
    input  rea_pkg::bsrc_e             mode,
    input  logic signed [PROD_W-1:0]   own_prod,
    input  logic signed [V_W-1:0]      va,
    input  logic signed [V_W-1:0]      vc,
    input  logic signed [I_W-1:0]      ib,
    output logic signed [PROD_W-1:0]   b_smp
);
    localparam int VD_W  = V_W + 2;
    localparam int MUL_W = VD_W + I_W;

    logic signed [VD_W-1:0]  vb_ac;
    logic signed [VD_W-1:0]  vb_a;
    logic signed [MUL_W-1:0] prod_ac;
    logic signed [MUL_W-1:0] prod_a;

    // Synthesise the phase B voltage candidates with sign extension.
    always_comb begin
        vb_ac = -VD_W'(va) - VD_W'(vc);
        vb_a  = -VD_W'(va);
    end

    // Exact signed products of the phase B current with each candidate voltage.
    always_comb begin
        prod_ac = MUL_W'(vb_ac) * MUL_W'(ib);
        prod_a  = MUL_W'(vb_a)  * MUL_W'(ib);
    end

    // Pick the sample that the selector asks for.
    always_comb begin
        unique case (mode)
            rea_pkg::BSRC_OWN:    b_smp = own_prod;
            rea_pkg::BSRC_ZERO:   b_smp = '0;
            rea_pkg::BSRC_NEG_AC: b_smp = PROD_W'(prod_ac);
            rea_pkg::BSRC_NEG_A:  b_smp = PROD_W'(prod_a);
            default:              b_smp = '0;
        endcase
    end

endmodule

// File: rtl/rea_phase.sv
// rea_phase: one phase's residue accumulator, threshold pulse generator and
// signed energy register with a sticky wrap flag.
// Assumes the sample magnitude never exceeds thr, which keeps the residue
// strictly inside (-thr, thr) and lets ACC_W stay small.
module rea_phase #(
    parameter int PROD_W = 36,
    parameter int TH_W   = 48,
    parameter int EN_W   = 32,
    parameter int ACC_W  = 50
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     smp_en,
    input  logic signed [PROD_W-1:0] smp,
    input  logic [TH_W-1:0]          thr,
    output logic                     pulse_pos,
    output logic                     pulse_neg,
    output logic signed [EN_W-1:0]   energy,
    output logic                     ovf
);
    localparam logic signed [EN_W-1:0] EN_MAX = {1'b0, {(EN_W-1){1'b1}}};
    localparam logic signed [EN_W-1:0] EN_MIN = {1'b1, {(EN_W-1){1'b0}}};

    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] sum;
    logic signed [ACC_W-1:0] thr_s;
    logic signed [ACC_W-1:0] acc_nxt;
    logic                    up;
    logic                    dn;
    logic signed [EN_W-1:0]  en_nxt;
    logic                    wrap;

    // Add the sample and compare the result against the threshold band.
    always_comb begin
        thr_s = $signed({{(ACC_W-TH_W){1'b0}}, thr});
        sum   = acc + ACC_W'(smp);
        up    = (sum >= thr_s);
        dn    = !up && (sum <= -thr_s);
        if (up)
            acc_nxt = sum - thr_s;
        else if (dn)
            acc_nxt = sum + thr_s;
        else
            acc_nxt = sum;
    end

    // Step the energy register by one count and detect a two's complement wrap.
    always_comb begin
        en_nxt = energy;
        wrap   = 1'b0;
        if (up) begin
            en_nxt = energy + EN_W'(1);
            wrap   = (energy == EN_MAX);
        end else if (dn) begin
            en_nxt = energy - EN_W'(1);
            wrap   = (energy == EN_MIN);
        end
    end

    // Register the residue, pulses, energy and sticky flag on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc       <= '0;
            pulse_pos <= 1'b0;
            pulse_neg <= 1'b0;
            energy    <= '0;
            ovf       <= 1'b0;
        end else begin
            pulse_pos <= 1'b0;
            pulse_neg <= 1'b0;
            if (smp_en) begin
                acc       <= acc_nxt;
                pulse_pos <= up;
                pulse_neg <= dn;
                energy    <= en_nxt;
                ovf       <= ovf | wrap;
            end
        end
    end

endmodule

// File: rtl/rea_top.sv
// rea_top: three-phase reactive energy pulse accumulator.
// Phases A and C integrate their own products. Phase B integrates the sample
// chosen by bsel. Each phase emits unit pulses at threshold crossings and
// counts them in a signed, wrapping energy register.
// Assumes a single clock and a synchronous active-low reset.
module rea_top #(
    parameter int V_W    = 16,
    parameter int I_W    = 16,
    parameter int PROD_W = 36,
    parameter int TH_W   = 48,
    parameter int EN_W   = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clr,
    input  logic                          smp_en,
    input  logic [TH_W-1:0]               thr,
    input  logic [1:0]                    bsel,
    input  logic signed [PROD_W-1:0]      pa_prod,
    input  logic signed [PROD_W-1:0]      pb_prod,
    input  logic signed [PROD_W-1:0]      pc_prod,
    input  logic signed [V_W-1:0]         va,
    input  logic signed [V_W-1:0]         vc,
    input  logic signed [I_W-1:0]         ib,
    output logic [2:0][EN_W-1:0]          energy,
    output logic [2:0]                    pulse_pos,
    output logic [2:0]                    pulse_neg,
    output logic [2:0]                    ovf
);
    localparam int NPH   = 3;
    localparam int ACC_W = ((TH_W > PROD_W) ? TH_W : PROD_W) + 2;

    logic signed [PROD_W-1:0] b_smp;
    logic signed [PROD_W-1:0] smp_vec [NPH];
    logic signed [EN_W-1:0]   en_w    [NPH];

    rea_bsel #(
        .V_W    (V_W),
        .I_W    (I_W),
        .PROD_W (PROD_W)
    ) u_bsel (
        .mode     (rea_pkg::bsrc_e'(bsel)),
        .own_prod (pb_prod),
        .va       (va),
        .vc       (vc),
        .ib       (ib),
        .b_smp    (b_smp)
    );

    // Route each phase's sample to its accumulator.
    always_comb begin
        smp_vec[0] = pa_prod;
        smp_vec[1] = b_smp;
        smp_vec[2] = pc_prod;
    end

    for (genvar g = 0; g < NPH; g++) begin : g_ph
        rea_phase #(
            .PROD_W (PROD_W),
            .TH_W   (TH_W),
            .EN_W   (EN_W),
            .ACC_W  (ACC_W)
        ) u_ph (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (clr),
            .smp_en    (smp_en),
            .smp       (smp_vec[g]),
            .thr       (thr),
            .pulse_pos (pulse_pos[g]),
            .pulse_neg (pulse_neg[g]),
            .energy    (en_w[g]),
            .ovf       (ovf[g])
        );
        assign energy[g] = en_w[g];
    end

endmodule

// File: rtl/rea_chk.sv
// rea_chk: temporal properties of the pulse accumulator, bound to rea_top.
module rea_chk #(
    parameter int NPH  = 3,
    parameter int EN_W = 32
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     clr,
    input logic                     smp_en,
    input logic [NPH-1:0][EN_W-1:0] energy,
    input logic [NPH-1:0]           pulse_pos,
    input logic [NPH-1:0]           pulse_neg,
    input logic [NPH-1:0]           ovf
);
    localparam logic [EN_W-1:0] EN_MIN = {1'b1, {(EN_W-1){1'b0}}};
    localparam logic [EN_W-1:0] EN_MAX = {1'b0, {(EN_W-1){1'b1}}};

    for (genvar g = 0; g < NPH; g++) begin : g_chk
        // R4
        no_dual_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(pulse_pos[g] && pulse_neg[g]));

        // R1
        idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!smp_en && !clr) |=> (!pulse_pos[g] && !pulse_neg[g] && $stable(energy[g]) && $stable(ovf[g])));

        // R7
        inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pulse_pos[g] |-> (energy[g] == $past(energy[g]) + EN_W'(1)));

        // R7
        dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pulse_neg[g] |-> (energy[g] == $past(energy[g]) - EN_W'(1)));

        // R8
        ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ovf[g] && !clr) |=> ovf[g]);

        // R8
        wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ((pulse_pos[g] && energy[g] == EN_MIN) || (pulse_neg[g] && energy[g] == EN_MAX)) |-> ovf[g]);

        // R9
        clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            clr |=> (energy[g] == '0 && !ovf[g] && !pulse_pos[g] && !pulse_neg[g]));
    end

endmodule

bind rea_top rea_chk #(
    .NPH  (3),
    .EN_W (EN_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .smp_en    (smp_en),
    .energy    (energy),
    .pulse_pos (pulse_pos),
    .pulse_neg (pulse_neg),
    .ovf       (ovf)
);

// File: tb/rea_top_bench.sv
// Bench: a behavioural reference model that is compared with the outputs on every clock.
module rea_top_bench;
    localparam int CLK_PER = 10;
    localparam int V_W     = 8;
    localparam int I_W     = 8;
    localparam int PROD_W  = 20;
    localparam int TH_W    = 48;
    localparam int EN_W    = 8;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     clr = 1'b0;
    logic                     smp_en = 1'b0;
    logic [TH_W-1:0]          thr = '0;
    logic [1:0]               bsel = 2'b00;
    logic signed [PROD_W-1:0] pa_prod = '0;
    logic signed [PROD_W-1:0] pb_prod = '0;
    logic signed [PROD_W-1:0] pc_prod = '0;
    logic signed [V_W-1:0]    va = '0;
    logic signed [V_W-1:0]    vc = '0;
    logic signed [I_W-1:0]    ib = '0;
    logic [2:0][EN_W-1:0]     energy;
    logic [2:0]               pulse_pos;
    logic [2:0]               pulse_neg;
    logic [2:0]               ovf;

    int     n_chk = 0;
    int     n_fail = 0;
    bit     done = 1'b0;
    longint m_acc [3];
    int     m_en  [3];
    bit     m_pp  [3];
    bit     m_pn  [3];
    bit     m_ovf [3];

    rea_top #(
        .V_W(V_W), .I_W(I_W), .PROD_W(PROD_W), .TH_W(TH_W), .EN_W(EN_W)
    ) u_rea_top (
        .clk(clk), .rst_n(rst_n), .clr(clr), .smp_en(smp_en), .thr(thr),
        .bsel(bsel), .pa_prod(pa_prod), .pb_prod(pb_prod), .pc_prod(pc_prod),
        .va(va), .vc(vc), .ib(ib), .energy(energy), .pulse_pos(pulse_pos),
        .pulse_neg(pulse_neg), .ovf(ovf)
    );

    always #(CLK_PER/2) clk = ~clk;

    // Phase sample as the requirements define it (R2, R3).
    function automatic longint ref_smp(int ph);
        if (ph == 0) return longint'(pa_prod);
        if (ph == 2) return longint'(pc_prod);
        case (bsel)
            2'b00:   return longint'(pb_prod);
            2'b01:   return 0;
            2'b10:   return (-longint'(va) - longint'(vc)) * longint'(ib);
            default: return (-longint'(va)) * longint'(ib);
        endcase
    endfunction

    task automatic model_step();
        for (int ph = 0; ph < 3; ph++) begin
            if (!rst_n || clr) begin
                m_acc[ph] = 0; m_en[ph] = 0; m_pp[ph] = 0; m_pn[ph] = 0; m_ovf[ph] = 0;
            end else begin
                m_pp[ph] = 0; m_pn[ph] = 0;
                if (smp_en) begin
                    longint s;
                    longint t;
                    s = m_acc[ph] + ref_smp(ph);
                    t = longint'(thr);
                    if (s >= t) begin
                        s = s - t; m_pp[ph] = 1; m_en[ph] = m_en[ph] + 1;
                    end else if (s <= -t) begin
                        s = s + t; m_pn[ph] = 1; m_en[ph] = m_en[ph] - 1;
                    end
                    if (m_en[ph] > 127) begin m_en[ph] -= 256; m_ovf[ph] = 1; end
                    if (m_en[ph] < -128) begin m_en[ph] += 256; m_ovf[ph] = 1; end
                    m_acc[ph] = s;
                end
            end
        end
    endtask

    task automatic chk(bit ok, string tag, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        for (int ph = 0; ph < 3; ph++) begin
            int e;
            e = int'($signed(energy[ph]));
            chk(e == m_en[ph], (ph == 1) ? "R3 R7 energy B" : "R2 R7 energy A/C", e, m_en[ph]);
            chk(pulse_pos[ph] == m_pp[ph], "R4 pulse_pos", pulse_pos[ph], m_pp[ph]);
            chk(pulse_neg[ph] == m_pn[ph], "R5 pulse_neg", pulse_neg[ph], m_pn[ph]);
            chk(ovf[ph] == m_ovf[ph], "R8 ovf", ovf[ph], m_ovf[ph]);
        end
    endtask

    // One clock: the model follows the edge, then outputs are compared away from it.
    task automatic cyc();
        @(posedge clk);
        model_step();
        #1;
        compare();
        @(negedge clk);
    endtask

    function automatic int rnd(int span);
        return int'($urandom_range(2 * span)) - span;
    endfunction

    initial begin
        #(CLK_PER * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R10: reset state
        repeat (3) cyc();
        chk(energy == '0 && pulse_pos == 0 && pulse_neg == 0 && ovf == 0, "R10 reset", energy, 0);
        rst_n = 1'b1;
        cyc();

        // R6: held sample equal to the threshold pulses on every strobe
        thr = 5000; bsel = 2'b00; smp_en = 1'b1;
        pa_prod = 5000; pb_prod = 5000; pc_prod = 5000;
        for (int k = 0; k < 10; k++) begin
            cyc();
            chk(pulse_pos == 3'b111, "R6 pulse per sample", pulse_pos, 7);
        end

        // R1: no strobe, large inputs, nothing moves
        smp_en = 1'b0; pa_prod = 4999; pb_prod = -4999; pc_prod = 4000;
        for (int k = 0; k < 5; k++) begin
            cyc();
            chk(pulse_pos == 0 && pulse_neg == 0, "R1 idle pulses", pulse_pos, 0);
        end

        // R5: negative samples crossing downward
        smp_en = 1'b1; pa_prod = -3000; pb_prod = -1700; pc_prod = -5000;
        repeat (20) cyc();

        // R2 R3: every phase B selector with random terms and strobe gaps
        thr = 40000;
        for (int m = 0; m < 4; m++) begin
            bsel = 2'(m);
            for (int k = 0; k < 60; k++) begin
                smp_en  = ($urandom_range(9) < 7);
                pa_prod = PROD_W'(rnd(30000));
                pb_prod = PROD_W'(rnd(30000));
                pc_prod = PROD_W'(rnd(30000));
                va = V_W'(rnd(127)); vc = V_W'(rnd(127)); ib = I_W'(rnd(127));
                cyc();
            end
        end

        // R3: largest synthesised magnitude, -(-128 - -128)... use extremes
        bsel = 2'b10; va = -128; vc = -128; ib = -128; smp_en = 1'b1;
        thr = 32768; pa_prod = 0; pc_prod = 0;
        repeat (3) cyc();

        // R9: clear wins over a strobe
        clr = 1'b1; cyc(); clr = 1'b0;
        chk(energy == '0 && ovf == 0, "R9 clear", energy, 0);

        // R8: upward wrap on A, downward wrap on C, B idle through zero selector
        thr = 100; bsel = 2'b01; pa_prod = 100; pb_prod = 100; pc_prod = -100;
        for (int k = 0; k < 300; k++) cyc();
        chk(ovf == 3'b101, "R8 sticky flags", ovf, 5);
        smp_en = 1'b0;
        repeat (3) cyc();

        // R9: clear after wraps
        clr = 1'b1; cyc(); clr = 1'b0; cyc();
        chk(ovf == 0, "R9 flags cleared", ovf, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule